// File: doc/BRIEF.md
# Paged Write Cache with Flush Sequencer

This block gathers the data bytes of one write transfer in a 64-byte cache arranged as 8 lines of 8 bytes. When the transfer is committed, it copies the cache into a page-organised array, one 8-byte page per write. A write command opens a load session and supplies a starting word address. The first data byte always lands in cache line 0, at the byte offset taken from the low three address bits. Each further byte goes to the next cache slot. After 64 slots the pointer wraps to slot 0 and overwrites earlier data.

A commit strobe (the STOP of the bus transfer) starts the flush. Cache line k goes to array page base+k, and the page index carries across the top of the array. In line 0, the slots below the start offset can only be filled after a wrap, so those bytes go to the page that follows line 7, base+8. Only loaded bytes are written. Each page write is followed by a fixed programming wait, and `busy` stays high from commit until the last wait ends. An abort strobe (for example a repeated START) discards the session without touching the array.

Top module: `wcache_flush`

## Requirements
- R1: After reset `busy` and `pg_we` are 0 and no load session is open, so a `commit` with no prior `wr_open` does nothing.
- R2: `wr_open` opens a session, clears all loaded marks and takes the base page from `wr_addr[ADDR_W-1:3]` and the start offset from `wr_addr[2:0]`; the first byte goes to cache line 0 at that offset.
- R3: Each accepted byte is stored at the current 6-bit slot pointer, and the pointer then advances by one. A byte is accepted only while a session is open, the block is idle, and `wr_open`, `commit` and `abort` are all low in that cycle.
- R4: Loading more than 64 bytes wraps the pointer to slot 0, and later bytes overwrite earlier ones.
- R5: A `commit` with at least one byte loaded raises `busy` in the next cycle. `busy` stays high for exactly LINES+1 + P*PROG_CYCLES cycles, where P is the number of pages written.
- R6: The flush walks LINES+1 steps in this order: step 0 writes line 0 lanes at or above the offset to page base; step k (1..LINES-1) writes line k to page base+k; the last step writes line 0 lanes below the offset to page base+LINES. Page indices wrap modulo the array page count.
- R7: `pg_be` marks only loaded lanes. A step with no loaded lane issues no write, so unloaded array bytes keep their contents.
- R8: `pg_we` is a one-cycle pulse, and two pulses are always at least PROG_CYCLES+1 cycles apart.
- R9: `abort` in an open session discards the cache and closes the session, and no array write follows, even after a later `commit`.
- R10: A `commit` in a session with no byte loaded closes the session without raising `busy` or writing.
- R11: While `busy` is high, `wr_open`, byte loads, `commit` and `abort` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_open | input | 1 | Start of a write command; captures `wr_addr` |
| wr_addr | input | ADDR_W | Starting word address |
| byte_vld | input | 1 | A data byte is present |
| byte_dat | input | 8 | Data byte |
| commit | input | 1 | End of transfer; starts the flush |
| abort | input | 1 | Transfer cancelled; discard the cache |
| busy | output | 1 | Flush in progress |
| pg_we | output | 1 | Page write strobe to the array |
| pg_idx | output | ADDR_W-3 | Array page index |
| pg_dat | output | 64 | Page data, lane b in bits 8b+7..8b |
| pg_be | output | 8 | Per-lane write enable |

## Verification
A wrong slot pointer or a stale loaded mark does not show during loading. It shows only at the flush, when a byte reaches the wrong array address or an unloaded lane is overwritten. The array image is therefore compared byte for byte after each flush. A wrong step order or page offset moves a whole page and shows in that same comparison. A timer or step-counter fault changes the number of write pulses, the length of `busy` or the spacing between pulses, and each of these is counted when the flush finishes.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PICK = 2'd1,
    SQ_PROG = 2'd2
  } sq_state_e;
endpackage

// File: rtl/wcf_store.sv
module wcf_store #(
  parameter int LINES  = 8,
  parameter int LBYTES = 8,
  parameter int ADDR_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 busy_i,
  input  logic                                 open_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic                                 byte_vld_i,
  input  logic [7:0]                           byte_i,
  input  logic                                 commit_i,
  input  logic                                 abort_i,
  input  logic [$clog2(LINES)-1:0]             rd_line_i,
  output logic [ADDR_W-$clog2(LBYTES)-1:0]     base_pg_o,
  output logic [$clog2(LBYTES)-1:0]            off_o,
  output logic [LBYTES*8-1:0]                  rd_data_o,
  output logic [LBYTES-1:0]                    rd_valid_o,
  output logic                                 flush_req_o
);
  localparam int OFF_W  = $clog2(LBYTES);
  localparam int LINE_W = $clog2(LINES);
  localparam int PTR_W  = OFF_W + LINE_W;
  localparam int SLOTS  = LINES * LBYTES;
  localparam int PAGE_W = ADDR_W - OFF_W;

  // first slot of a transfer: line 0, offset from the low address bits
  function automatic logic [PTR_W-1:0] first_slot(input logic [ADDR_W-1:0] a);
    return PTR_W'(a[OFF_W-1:0]);
  endfunction

  logic [7:0]        cache_q [SLOTS];
  logic [SLOTS-1:0]  vmask_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              sess_q;
  logic [PAGE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;

  // accepted events, named for the checks
  logic acc_open, acc_abort, acc_commit, acc_byte;
  assign acc_open   = open_i & ~busy_i;
  assign acc_abort  = abort_i & sess_q & ~busy_i & ~open_i;
  assign acc_commit = commit_i & sess_q & ~busy_i & ~open_i & ~abort_i;
  assign acc_byte   = byte_vld_i & sess_q & ~busy_i & ~open_i & ~abort_i & ~commit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q  <= 1'b0;
      vmask_q <= '0;
      ptr_q   <= '0;
      base_q  <= '0;
      off_q   <= '0;
    end else if (acc_open) begin
      sess_q  <= 1'b1;
      vmask_q <= '0;
      ptr_q   <= first_slot(addr_i);
      base_q  <= addr_i[ADDR_W-1:OFF_W];
      off_q   <= addr_i[OFF_W-1:0];
    end else if (acc_abort) begin
      sess_q  <= 1'b0;
      vmask_q <= '0;
    end else if (acc_commit) begin
      sess_q  <= 1'b0;
    end else if (acc_byte) begin
      vmask_q[ptr_q] <= 1'b1;
      ptr_q          <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_byte) cache_q[ptr_q] <= byte_i;
  end

  for (genvar b = 0; b < LBYTES; b++) begin : g_lane
    assign rd_data_o[b*8 +: 8] = cache_q[{rd_line_i, OFF_W'(b)}];
    assign rd_valid_o[b]       = vmask_q[{rd_line_i, OFF_W'(b)}];
  end

  assign base_pg_o   = base_q;
  assign off_o       = off_q;
  assign flush_req_o = acc_commit & (|vmask_q);

  AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_open |=> (sess_q && vmask_q == '0)); // R2
  AST_BYTE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_byte |=> vmask_q[$past(ptr_q)]); // R3
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |=> (!sess_q && vmask_q == '0)); // R9
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(vmask_q)); // R11
endmodule

// File: rtl/wcf_seq.sv
module wcf_seq
  import wcf_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int LBYTES      = 8,
  parameter int ADDR_W      = 12,
  parameter int PROG_CYCLES = 100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [ADDR_W-$clog2(LBYTES)-1:0] base_pg_i,
  input  logic [$clog2(LBYTES)-1:0]        off_i,
  input  logic [LBYTES*8-1:0]              line_data_i,
  input  logic [LBYTES-1:0]                line_valid_i,
  output logic [$clog2(LINES)-1:0]         rd_line_o,
  output logic                             busy_o,
  output logic                             pg_we_o,
  output logic [ADDR_W-$clog2(LBYTES)-1:0] pg_idx_o,
  output logic [LBYTES*8-1:0]              pg_dat_o,
  output logic [LBYTES-1:0]                pg_be_o
);
  localparam int OFF_W  = $clog2(LBYTES);
  localparam int LINE_W = $clog2(LINES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int STEPS  = LINES + 1;
  localparam int STEP_W = $clog2(STEPS);
  localparam int TMR_W  = $clog2(PROG_CYCLES + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(LINES);

  // cache line read in a step: the last step revisits line 0
  function automatic logic [LINE_W-1:0] step_line(input logic [STEP_W-1:0] s);
    return (s >= LAST) ? '0 : s[LINE_W-1:0];
  endfunction

  // lanes owned by a step: line 0 is split at the start offset
  function automatic logic [LBYTES-1:0] step_lanes(input logic [STEP_W-1:0] s,
                                                   input logic [OFF_W-1:0]  o);
    logic [LBYTES-1:0] m;
    for (int b = 0; b < LBYTES; b++) begin
      if (s == '0)        m[b] = (b >= int'(o));
      else if (s == LAST) m[b] = (b < int'(o));
      else                m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [PAGE_W-1:0] step_page(input logic [PAGE_W-1:0] base,
                                                  input logic [STEP_W-1:0] s);
    return base + PAGE_W'(s);
  endfunction

  sq_state_e          st_q;
  logic [STEP_W-1:0]  step_q;
  logic [TMR_W-1:0]   tmr_q;

  assign rd_line_o = step_line(step_q);
  assign pg_be_o   = line_valid_i & step_lanes(step_q, off_i);
  assign pg_dat_o  = line_data_i;
  assign pg_idx_o  = step_page(base_pg_i, step_q);
  assign pg_we_o   = (st_q == SQ_PICK) && (|pg_be_o);
  assign busy_o    = (st_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      step_q <= '0;
      tmr_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q   <= SQ_PICK;
          step_q <= '0;
        end
        SQ_PICK: begin
          if (pg_we_o) begin
            st_q  <= SQ_PROG;
            tmr_q <= TMR_W'(PROG_CYCLES - 1);
          end else if (step_q == LAST) begin
            st_q <= SQ_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        SQ_PROG: begin
          if (tmr_q == '0) begin
            if (step_q == LAST) st_q <= SQ_IDLE;
            else begin
              st_q   <= SQ_PICK;
              step_q <= step_q + 1'b1;
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // cycles since the last page write, saturating; used by the spacing check
  logic [TMR_W:0] since_q;
  logic           seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (pg_we_o) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o); // R5
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we_o |=> (!pg_we_o && busy_o)); // R8
  AST_PROG_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_we_o && seen_q) |-> (since_q >= (TMR_W+1)'(PROG_CYCLES))); // R8
endmodule

// File: rtl/wcache_flush.sv
module wcache_flush #(
  parameter int ADDR_W      = 12,
  parameter int LINES       = 8,
  parameter int LBYTES      = 8,
  parameter int PROG_CYCLES = 100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_open,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic                             byte_vld,
  input  logic [7:0]                       byte_dat,
  input  logic                             commit,
  input  logic                             abort,
  output logic                             busy,
  output logic                             pg_we,
  output logic [ADDR_W-$clog2(LBYTES)-1:0] pg_idx,
  output logic [LBYTES*8-1:0]              pg_dat,
  output logic [LBYTES-1:0]                pg_be
);
  localparam int OFF_W  = $clog2(LBYTES);
  localparam int LINE_W = $clog2(LINES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0]     base_pg;
  logic [OFF_W-1:0]      start_off;
  logic [LINE_W-1:0]     rd_line;
  logic [LBYTES*8-1:0]   line_data;
  logic [LBYTES-1:0]     line_valid;
  logic                  flush_req;

  wcf_store #(.LINES(LINES), .LBYTES(LBYTES), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy),
    .open_i     (wr_open),
    .addr_i     (wr_addr),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_dat),
    .commit_i   (commit),
    .abort_i    (abort),
    .rd_line_i  (rd_line),
    .base_pg_o  (base_pg),
    .off_o      (start_off),
    .rd_data_o  (line_data),
    .rd_valid_o (line_valid),
    .flush_req_o(flush_req)
  );

  wcf_seq #(.LINES(LINES), .LBYTES(LBYTES), .ADDR_W(ADDR_W),
            .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (flush_req),
    .base_pg_i   (base_pg),
    .off_i       (start_off),
    .line_data_i (line_data),
    .line_valid_i(line_valid),
    .rd_line_o   (rd_line),
    .busy_o      (busy),
    .pg_we_o     (pg_we),
    .pg_idx_o    (pg_idx),
    .pg_dat_o    (pg_dat),
    .pg_be_o     (pg_be)
  );

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !flush_req); // R11
  AST_FLUSH_BASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base_pg)); // R6
endmodule

// File: tb/sim_wcache_flush.sv
module sim_wcache_flush;
  localparam int AW = 10;
  localparam int NL = 8;
  localparam int NB = 8;
  localparam int PC = 6;
  localparam int PW = AW - 3;
  localparam int ASZ = 1 << AW;

  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] nbytes;
    logic [15:0] pages;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{16'h010, 16'd1,   16'd1},
    '{16'h013, 16'd8,   16'd2},
    '{16'h020, 16'd64,  16'd8},
    '{16'h03D, 16'd64,  16'd9},
    '{16'h3F8, 16'd20,  16'd3},
    '{16'h042, 16'd70,  16'd9},
    '{16'h100, 16'd0,   16'd0},
    '{16'h1F7, 16'd9,   16'd2},
    '{16'h080, 16'd130, 16'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr_open = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          byte_vld = 1'b0;
  logic [7:0]    byte_dat = '0;
  logic          commit = 1'b0;
  logic          abort = 1'b0;
  logic          busy, pg_we;
  logic [PW-1:0] pg_idx;
  logic [63:0]   pg_dat;
  logic [7:0]    pg_be;

  wcache_flush #(.ADDR_W(AW), .LINES(NL), .LBYTES(NB), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .commit(commit), .abort(abort),
    .busy(busy), .pg_we(pg_we), .pg_idx(pg_idx), .pg_dat(pg_dat), .pg_be(pg_be)
  );

  logic [7:0] amem [ASZ];
  logic [7:0] emem [ASZ];
  int n_chk = 0, n_bad = 0;
  int we_cnt = 0, busy_cnt = 0, cyc = 0, last_we = -1000, short_gap = 0;

  // behavioural array and event counters
  always @(posedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (pg_we) begin
      we_cnt++;
      if (cyc - last_we < PC + 1) short_gap++;
      last_we = cyc;
      for (int b = 0; b < 8; b++)
        if (pg_be[b]) amem[{pg_idx, 3'(b)}] = pg_dat[b*8 +: 8];
    end
  end

  task automatic report;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int v, input int i);
    return 8'(v * 53 + i * 29 + 17);
  endfunction

  task automatic drive_open(input int a);
    wr_open = 1'b1; wr_addr = AW'(a);
    @(negedge clk);
    wr_open = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    byte_vld = 1'b1; byte_dat = d;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic do_commit;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic wait_idle;
    int g = 0;
    while (busy && g < 5000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  // expected image: byte i goes to slot (off+i)%64; slots below off belong to page base+8
  task automatic model(input int a, input int n, input int v);
    logic [7:0] img [64];
    bit ld [64];
    int off = a % 8;
    int base = a / 8;
    for (int s = 0; s < 64; s++) ld[s] = 1'b0;
    for (int i = 0; i < n; i++) begin
      img[(off + i) % 64] = dat(v, i);
      ld[(off + i) % 64] = 1'b1;
    end
    for (int s = 0; s < 64; s++)
      if (ld[s]) emem[(base * 8 + s + ((s < off) ? 64 : 0)) % ASZ] = img[s];
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < ASZ; a++)
      if (amem[a] !== emem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    if (first < 0) first = 0;
    chk(bad == 0, req, $sformatf("array mismatches (first at %0d: %0h vs %0h)",
        first, amem[first], emem[first]), bad, 0);
  endtask

  initial begin
    int w0, b0;
    for (int a = 0; a < ASZ; a++) begin
      amem[a] = 8'(a * 3 + 5);
      emem[a] = 8'(a * 3 + 5);
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(pg_we == 1'b0, "R1", "pg_we in reset", int'(pg_we), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: commit with no session open
    w0 = we_cnt; b0 = busy_cnt;
    do_commit;
    repeat (3) @(negedge clk);
    chk(busy_cnt == b0, "R1", "busy cycles after bare commit", busy_cnt - b0, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int a = int'(VT[v].addr);
      int n = int'(VT[v].nbytes);
      int p = int'(VT[v].pages);
      int eb = (p == 0) ? 0 : (NL + 1 + p * PC);
      w0 = we_cnt; b0 = busy_cnt;
      drive_open(a);
      for (int i = 0; i < n; i++) push(dat(v, i));
      do_commit;
      wait_idle;
      model(a, n, v);
      cmp_mem(n > 64 ? "R4 R7" : "R2 R7");
      chk(we_cnt - w0 == p, (p == 0) ? "R10" : "R6", "page writes", we_cnt - w0, p);
      chk(busy_cnt - b0 == eb, "R5", "busy cycles", busy_cnt - b0, eb);
    end
    chk(short_gap == 0, "R8", "closely spaced write pulses", short_gap, 0);

    // R9: abort discards, later commit does nothing
    w0 = we_cnt; b0 = busy_cnt;
    drive_open(16'h050);
    for (int i = 0; i < 5; i++) push(dat(40, i));
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    do_commit;
    repeat (4) @(negedge clk);
    chk(we_cnt == w0, "R9", "writes after abort", we_cnt - w0, 0);
    chk(busy_cnt == b0, "R9", "busy after abort", busy_cnt - b0, 0);
    cmp_mem("R9");

    // R3: byte in the same cycle as wr_open is dropped
    w0 = we_cnt;
    wr_open = 1'b1; wr_addr = AW'(16'h0A5); byte_vld = 1'b1; byte_dat = 8'hEE;
    @(negedge clk);
    wr_open = 1'b0; byte_vld = 1'b0;
    push(dat(50, 0));
    do_commit;
    wait_idle;
    model(16'h0A5, 1, 50);
    cmp_mem("R3");
    chk(we_cnt - w0 == 1, "R3", "page writes for one byte", we_cnt - w0, 1);

    // R11: commands during a flush are ignored
    w0 = we_cnt; b0 = busy_cnt;
    drive_open(16'h200);
    for (int i = 0; i < 64; i++) push(dat(60, i));
    do_commit;
    chk(busy == 1'b1, "R5", "busy after commit", int'(busy), 1);
    drive_open(16'h300);
    for (int i = 0; i < 3; i++) push(8'h3C);
    do_commit;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    wait_idle;
    model(16'h200, 64, 60);
    cmp_mem("R11");
    chk(we_cnt - w0 == 8, "R11", "page writes with ignored commands", we_cnt - w0, 8);
    chk(busy_cnt - b0 == NL + 1 + 8 * PC, "R11", "busy cycles", busy_cnt - b0, NL + 1 + 8 * PC);
    w0 = we_cnt;
    do_commit;
    repeat (4) @(negedge clk);
    chk(we_cnt == w0, "R11", "commit after ignored open", we_cnt - w0, 0);
    chk(short_gap == 0, "R8", "closely spaced write pulses", short_gap, 0);

    report;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
    report;
  end
endmodule